// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block collects 31-bit transmit words from a host whose parallel data bus is only 16 bits wide, and holds them in an eight-entry first-in first-out queue. A downstream serializer drains the queue. The host presents the low half of a word on the bus and pulses the low-half strobe. It then presents the high half and pulses the high-half strobe. On the clock edge after the high-half strobe is sampled, the assembled word enters the next free slot of the queue. The host takes no further action.

The serializer sees the oldest stored word together with a valid flag. It removes that word with a one-cycle pop pulse. A transmitter-ready flag is high whenever the queue holds nothing, and a 4-bit occupancy value gives the number of stored words. Words that complete while the queue is full are dropped, and the stored words stay as they were. The synchronous master reset empties the queue and discards any half-loaded word.

Top module: `txword_queue`

## Requirements
- R1: While master reset is applied, and on the first cycle after it is released, `tx_ready` is 1, `head_valid` is 0 and `occupancy` is 0.
- R2: A low-half strobe captures `bus_data[15:0]` as word bits 15:0. A later high-half strobe captures `bus_data[14:0]` as word bits 30:16, and `bus_data[15]` is ignored. The completed word is stored at the clock edge after the edge that samples the high-half strobe. At that same edge `occupancy` increments.
- R3: `head_word` always shows the oldest stored word. A pop sampled while `head_valid` is 1 removes that word, so the words leave in the order they were loaded.
- R4: When `occupancy` is 8, a completed word is discarded, `occupancy` stays at 8, and the eight stored words are unchanged and still in order.
- R5: A high-half strobe with no low half pending stores nothing.
- R6: A second low-half strobe before the high half replaces the pending low half.
- R7: If both strobes are sampled in the same cycle, the cycle counts as a low-half strobe only, and the high-half strobe is ignored.
- R8: `tx_ready` is 1 exactly when `occupancy` is 0, and `head_valid` is 1 exactly when `occupancy` is not 0.
- R9: A pop sampled while the queue is empty has no effect.
- R10: Master reset applied while words are stored and a low half is pending empties the queue and discards the pending half.
- R11: If a word is stored and a pop is sampled at the same edge, on a queue that is neither empty nor full, `occupancy` is unchanged. The head advances, and the new word joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| bus_data | input | 16 | Host data bus carrying one half of a word |
| ld_lo | input | 1 | Strobe capturing word bits 15:0 |
| ld_hi | input | 1 | Strobe capturing word bits 30:16 and completing the word |
| pop | input | 1 | Serializer removes the oldest word |
| head_word | output | 31 | Oldest stored word |
| head_valid | output | 1 | `head_word` holds a stored word |
| tx_ready | output | 1 | Queue is empty |
| occupancy | output | 4 | Number of stored words, 0 to 8 |

## Verification
A read or write pointer that has slipped out of step shows up at the first pop as a `head_word` out of order or repeated. For this reason every pop is compared against a model of the queue, and that includes runs that fill the queue past its capacity. A count that has drifted away from the pointers appears on `occupancy` and on the two flags one edge after the push or pop that caused it. The pending-half state cannot be seen directly. An error in it shows as a word appearing or failing to appear two edges after a high-half strobe. It can also show as wrong low bits in a stored word, and each ordering test is built to expose those cases.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef enum logic {
    HALF_EMPTY = 1'b0,
    HALF_HELD  = 1'b1
  } half_state_e;

endpackage

// File: rtl/txq_assembler.sv
module txq_assembler
  import txq_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  output logic [WORD_W-1:0] word_o,
  output logic              push_o
);

  localparam int unsigned HI_W = WORD_W - BUS_W;

  half_state_e      st_q;
  logic [BUS_W-1:0] lo_q;
  logic             unused_bus_top;

  // Bus bits above the high half carry nothing.
  assign unused_bus_top = ^bus_data[BUS_W-1:HI_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= HALF_EMPTY;
      push_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (ld_lo) begin
        // Low strobe wins, including when both strobes arrive together.
        lo_q <= bus_data;
        st_q <= HALF_HELD;
      end else if (ld_hi && st_q == HALF_HELD) begin
        word_o <= {bus_data[HI_W-1:0], lo_q};
        push_o <= 1'b1;
        st_q   <= HALF_EMPTY;
      end
    end
  end

  // R5: an orphan high strobe never produces a push
  a_r5_orphan_hi: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_lo && st_q == HALF_EMPTY) |=> !push_o);

  // R2: a high strobe on a held half always produces a push
  a_r2_completes: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !ld_lo && st_q == HALF_HELD) |=> push_o);

  // R7: simultaneous strobes never push
  a_r7_lo_wins: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && ld_lo) |=> (!push_o && st_q == HALF_HELD));

endmodule

// File: rtl/txq_store.sv
module txq_store #(
  parameter int unsigned WORD_W = 31,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read; new data forwarded when the read slot is being written.
  always_ff @(posedge clk) begin
    if (we && waddr == raddr) rdata <= wdata;
    else                      rdata <= mem[raddr];
  end

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] count_q,
  output logic          ready_q,
  output logic          valid_q
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_n;
  logic [CW-1:0] count_n;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign push_ok  = push && (count_q != FULL_CNT);
  assign pop_ok   = pop && (count_q != '0);
  assign rd_ptr_n = pop_ok ? step(rd_ptr_q) : rd_ptr_q;

  always_comb begin
    count_n = count_q;
    if (push_ok && !pop_ok)      count_n = count_q + 1'b1;
    else if (pop_ok && !push_ok) count_n = count_q - 1'b1;
  end

  assign we    = push_ok;
  assign waddr = wr_ptr_q;
  assign raddr = rd_ptr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ready_q  <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= step(wr_ptr_q);
      rd_ptr_q <= rd_ptr_n;
      count_q  <= count_n;
      ready_q  <= (count_n == '0);
      valid_q  <= (count_n != '0);
    end
  end

  // R4: occupancy never exceeds the depth
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL_CNT);

  // R4: a push at full leaves the count at full
  a_r4_full_hold: assert property (@(posedge clk) disable iff (rst)
    (count_q == FULL_CNT && push && !pop) |=> count_q == FULL_CNT);

  // R8: flags agree with the count
  a_r8_flags: assert property (@(posedge clk) disable iff (rst)
    (ready_q == (count_q == '0)) && (valid_q == (count_q != '0)));

  // R9: pop on empty with no push keeps the queue empty
  a_r9_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && count_q == '0) |=> count_q == '0);

  // R11: push and pop together leave the count unchanged
  a_r11_balance: assert property (@(posedge clk) disable iff (rst)
    (push && pop && count_q != '0 && count_q != FULL_CNT) |=> $stable(count_q));

  // R10 / R1: master reset empties the queue
  a_r10_reset_empties: assert property (@(posedge clk)
    rst |=> (count_q == '0 && ready_q && !valid_q));

endmodule

// File: rtl/txword_queue.sv
module txword_queue #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WORD_W = 31,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  bus_data,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              pop,
  output logic [WORD_W-1:0] head_word,
  output logic              head_valid,
  output logic              tx_ready,
  output logic [CW-1:0]     occupancy
);

  logic [WORD_W-1:0] asm_word;
  logic              asm_push;
  logic              wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;

  txq_assembler #(.BUS_W(BUS_W), .WORD_W(WORD_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .bus_data (bus_data),
    .ld_lo    (ld_lo),
    .ld_hi    (ld_hi),
    .word_o   (asm_word),
    .push_o   (asm_push)
  );

  txq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .push    (asm_push),
    .pop     (pop),
    .we      (wr_en),
    .waddr   (wr_addr),
    .raddr   (rd_addr),
    .count_q (occupancy),
    .ready_q (tx_ready),
    .valid_q (head_valid)
  );

  txq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (asm_word),
    .raddr (rd_addr),
    .rdata (head_word)
  );

  // R1: one cycle after reset the outputs show an empty queue
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (tx_ready && !head_valid && occupancy == '0));

  // R3: the head word holds while nothing is popped and the queue is non-empty
  a_r3_head_hold: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !pop && !asm_push) |=> $stable(head_word));

endmodule

// File: tb/txword_queue_test.sv
module txword_queue_test;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] bus_data;
  logic        ld_lo, ld_hi, pop;
  logic [30:0] head_word;
  logic        head_valid, tx_ready;
  logic [3:0]  occupancy;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [30:0] model[$];

  always #5 clk = ~clk;

  txword_queue uut (
    .clk(clk), .rst(rst), .bus_data(bus_data), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .pop(pop), .head_word(head_word), .head_valid(head_valid),
    .tx_ready(tx_ready), .occupancy(occupancy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_status(input string req);
    chk(req, {28'd0, occupancy}, model.size());
    chk(req, {31'd0, tx_ready}, (model.size() == 0));
    chk(req, {31'd0, head_valid}, (model.size() != 0));
    if (model.size() != 0) chk(req, {1'b0, head_word}, {1'b0, model[0]});
  endtask

  task automatic mreset();
    @(negedge clk); rst = 1'b1; ld_lo = 0; ld_hi = 0; pop = 0; bus_data = '0;
    @(negedge clk); rst = 1'b0;
    model.delete();
  endtask

  task automatic load_word(input logic [30:0] w);
    @(negedge clk); ld_lo = 1; bus_data = w[15:0];
    @(negedge clk); ld_lo = 0; ld_hi = 1; bus_data = {1'b1, w[30:16]};
    @(negedge clk); ld_hi = 0; bus_data = 16'hFFFF;
    @(negedge clk);
    if (model.size() < 8) model.push_back(w);
  endtask

  task automatic pop_word(input string req);
    @(negedge clk); pop = 1;
    @(negedge clk); pop = 0;
    if (model.size() != 0) void'(model.pop_front());
    chk_status(req);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1; ld_lo = 0; ld_hi = 0; pop = 0; bus_data = '0;
    @(negedge clk);
    chk("R1 ready", {31'd0, tx_ready}, 1);
    chk("R1 valid", {31'd0, head_valid}, 0);
    chk("R1 occ", {28'd0, occupancy}, 0);
    rst = 0;
    @(negedge clk);
    chk("R1 occ after release", {28'd0, occupancy}, 0);
    model.delete();
  endtask

  task automatic t_single();
    load_word(31'h5A5A_C3C3);
    chk_status("R2 single word");
    chk("R8 ready low", {31'd0, tx_ready}, 0);
    pop_word("R8 empty after pop");
  endtask

  task automatic t_order();
    load_word(31'h0000_0001);
    load_word(31'h7FFF_FFFF);
    load_word(31'h2345_6789);
    chk_status("R3 three loaded");
    pop_word("R3 order 1");
    pop_word("R3 order 2");
    pop_word("R3 order 3");
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) load_word(31'(32'h0100_0000 * (i + 1) + i));
    chk_status("R4 filled");
    load_word(31'h7EAD_BEEF);
    chk_status("R4 ninth dropped");
    for (int i = 0; i < 8; i++) pop_word("R4 drain order");
  endtask

  task automatic t_orphan();
    @(negedge clk); ld_hi = 1; bus_data = 16'h1234;
    @(negedge clk); ld_hi = 0;
    @(negedge clk);
    chk_status("R5 orphan hi");
  endtask

  task automatic t_relo();
    @(negedge clk); ld_lo = 1; bus_data = 16'hAAAA;
    @(negedge clk); bus_data = 16'h0F0F;
    @(negedge clk); ld_lo = 0; ld_hi = 1; bus_data = 16'h0246;
    @(negedge clk); ld_hi = 0;
    @(negedge clk);
    model.push_back({15'h0246, 16'h0F0F});
    chk_status("R6 relo overwrite");
    pop_word("R6 drain");
  endtask

  task automatic t_both();
    @(negedge clk); ld_lo = 1; ld_hi = 1; bus_data = 16'h1357;
    @(negedge clk); ld_lo = 0; ld_hi = 0;
    @(negedge clk);
    chk_status("R7 both no push");
    @(negedge clk); ld_hi = 1; bus_data = 16'h8642;
    @(negedge clk); ld_hi = 0;
    @(negedge clk);
    model.push_back({15'h0642, 16'h1357});
    chk_status("R7 both became lo");
    pop_word("R7 drain");
  endtask

  task automatic t_pop_empty();
    pop_word("R9 pop empty");
    load_word(31'h1111_2222);
    chk_status("R9 load after empty pop");
    pop_word("R9 drain");
  endtask

  task automatic t_mreset();
    load_word(31'h0ABC_DEF0);
    load_word(31'h1234_5678);
    @(negedge clk); ld_lo = 1; bus_data = 16'h5555;
    @(negedge clk); ld_lo = 0;
    mreset();
    chk_status("R10 cleared");
    @(negedge clk); ld_hi = 1; bus_data = 16'h0001;
    @(negedge clk); ld_hi = 0;
    @(negedge clk);
    chk_status("R10 pending dropped");
  endtask

  task automatic t_simul();
    load_word(31'h0000_AAAA);
    load_word(31'h0000_BBBB);
    @(negedge clk); ld_lo = 1; bus_data = 16'hCCCC;
    @(negedge clk); ld_lo = 0; ld_hi = 1; bus_data = 16'h0033;
    @(negedge clk); ld_hi = 0; pop = 1;
    @(negedge clk); pop = 0;
    void'(model.pop_front());
    model.push_back({15'h0033, 16'hCCCC});
    chk_status("R11 push and pop");
    pop_word("R11 drain a");
    pop_word("R11 drain b");
  endtask

  initial begin
    rst = 1; ld_lo = 0; ld_hi = 0; pop = 0; bus_data = '0;
    t_reset();
    t_single();
    t_order();
    t_full();
    t_orphan();
    t_relo();
    t_both();
    t_pop_empty();
    t_mreset();
    t_simul();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule